// File: doc/BRIEF.md
# Periodic Interrupt and Status Controller

This block implements the four control and status registers of a real-time clock's register file. It sits beside the time-keeping logic and takes a one-cycle tick at the 32.768 kHz base rate. From that tick it divides down to a programmable periodic event. The same event drives a square-wave output.

The block collects three kinds of event: update-ended, alarm and periodic. Each has its own sticky flag in the status register. A summary bit and a single active-high interrupt line follow whichever flags are enabled. Software selects registers through a 4-bit index. The four registers sit at consecutive indices starting at `BASE_IDX` (default 10). Reading the status register clears it. A battery-good input is reflected as a validity bit.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, the rate/divider register (index 10), the enable register (index 11) and the status register (index 12) read 0x00, and `irq` and `sqw` are low.
- R2: Index 10 stores bits 6:0 of a write and reads bit 7 as 0. Index 11 stores all eight bits, including the daylight-saving bit 0, and reads them back.
- R3: For rate codes 3 to 15 in bits 3:0 of index 10, the periodic event recurs every 2^(code-1) ticks. Rate code 0 produces no periodic event.
- R4: With the divider field (bits 6:4 of index 10) at 010, the 32 kHz base, rate codes 1 and 2 give periods of 128 and 256 ticks. With the field at 000 or 001, codes 1 and 2 give periods of 1 and 2 ticks.
- R5: Divider field values 110 and 111 hold the divider in reset, and no periodic event occurs. After the field leaves a reset value, the first periodic event comes a full period after that write.
- R6: The status register holds the update-ended flag in bit 4, the alarm flag in bit 5 and the periodic flag in bit 6. Each flag is set by its event whether or not its enable bit is set. Status bits 3:0 read as 0.
- R7: Status bit 7 and `irq` are high exactly when a set flag has its enable bit set. The enables are bit 4 of index 11 for update-ended, bit 5 for alarm and bit 6 for periodic.
- R8: A read of the status register returns its current contents and then clears all its flags. An event in the same cycle as the read is kept.
- R9: Writes to index 12 and index 13 change nothing.
- R10: Index 13 reads bit 7 equal to `batt_ok`, and its other bits read 0.
- R11: With bit 3 of index 11 set, `sqw` toggles on every periodic event. With it clear, `sqw` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at the 32.768 kHz base rate |
| addr | input | 4 | Register index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears the status register when it selects index 12) |
| rd_data | output | 8 | Read data for the selected index, valid in the same cycle |
| upd_evt | input | 1 | Update-ended event pulse |
| alm_evt | input | 1 | Alarm event pulse |
| batt_ok | input | 1 | Battery-good indication |
| sqw | output | 1 | Square-wave output |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with the default `CNT_W` of 14 and `BASE_IDX` of 10, and holds `tick` high every cycle. Every period therefore equals its tick count in clock cycles. The slowest rate, code 15 at 16384 ticks, stays reachable in one run, so all three period families can be timed exactly from the write that starts the divider: the halving codes, the 32 kHz special codes and the fast 1- and 2-tick codes.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int CNT_W = 14,
  parameter logic [3:0] BASE_IDX = 4'd10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       upd_evt,
  input  logic       alm_evt,
  input  logic       batt_ok,
  output logic       sqw,
  output logic       irq
);
  localparam logic [3:0] IDX_A = BASE_IDX;
  localparam logic [3:0] IDX_B = BASE_IDX + 4'd1;
  localparam logic [3:0] IDX_C = BASE_IDX + 4'd2;
  localparam logic [3:0] IDX_D = BASE_IDX + 4'd3;

  logic [6:0]       reg_a;
  logic [7:0]       reg_b;
  logic             uf, af, pf;
  logic [CNT_W-1:0] cnt;
  logic [4:0]       shamt;
  logic [CNT_W:0]   one_sh;
  logic [CNT_W-1:0] mask;

  wire [3:0] rate     = reg_a[3:0];
  wire       div_hold = reg_a[6:5] == 2'b11;
  wire       base32   = reg_a[6:4] == 3'b010;
  wire       wr_a     = wr_en && addr == IDX_A;
  wire       wr_b     = wr_en && addr == IDX_B;
  wire       rd_c     = rd_en && addr == IDX_C;

  always_comb begin
    if (base32 && (rate == 4'd1 || rate == 4'd2)) shamt = 5'(rate) + 5'd6;
    else                                          shamt = 5'(rate) - 5'd1;
    one_sh = (CNT_W+1)'(1) << shamt;
    mask   = CNT_W'(one_sh - 1'b1);
  end

  wire pe = tick && !div_hold && rate != 4'd0 && (cnt & mask) == mask;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (div_hold) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (wr_a) reg_a <= wr_data[6:0];
      if (wr_b) reg_b <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf <= 1'b0;
      af <= 1'b0;
      pf <= 1'b0;
    end else begin
      uf <= upd_evt | (uf & ~rd_c);
      af <= alm_evt | (af & ~rd_c);
      pf <= pe      | (pf & ~rd_c);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sqw <= 1'b0;
    else if (!reg_b[3]) sqw <= 1'b0;
    else if (pe) sqw <= ~sqw;
  end

  assign irq = (uf & reg_b[4]) | (af & reg_b[5]) | (pf & reg_b[6]);

  always_comb begin
    case (addr)
      IDX_A:   rd_data = {1'b0, reg_a};
      IDX_B:   rd_data = reg_b;
      IDX_C:   rd_data = {irq, pf, af, uf, 4'b0000};
      IDX_D:   rd_data = {batt_ok, 7'b0};
      default: rd_data = 8'h00;
    endcase
  end

  p_hold_no_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> !$changed(sqw) || !reg_b[3]);
  p_sqw_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_b[3] |=> !sqw);
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !upd_evt && !alm_evt && !pe) |=> !uf && !af && !pf);
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(upd_evt || alm_evt || pe || wr_b));
  p_c_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr == IDX_C |-> rd_data[3:0] == 4'h0);
  p_d_layout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr == IDX_D |-> rd_data == {batt_ok, 7'b0});
  p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> uf);
endmodule

// File: tb/tb_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rtc_irq_ctrl;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [3:0] addr = 0;
  logic wr_en = 0, rd_en = 0, upd_evt = 0, alm_evt = 0, batt_ok = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic sqw, irq;

  rtc_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .upd_evt(upd_evt), .alm_evt(alm_evt), .batt_ok(batt_ok), .sqw(sqw), .irq(irq));

  always #2 clk = ~clk;

  typedef struct {
    int kind;
    int expv;
    int actv;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0: act = int'(rd_data);
        1: act = int'(irq);
        2: act = int'(sqw);
        default: act = it.actv;
      endcase
      checks++;
      if (act != it.expv) begin
        errors++;
        $display("FAIL %s actual %0d expected %0d", it.tag, act, it.expv);
      end
    end
  end

  task automatic push(int kind, int expv, int actv, string tag);
    item_t it;
    it.kind = kind; it.expv = expv; it.actv = actv; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    step();
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, int expv, string tag);
    addr = a; rd_en = 1;
    push(0, expv, 0, tag);
    step();
    rd_en = 0;
  endtask

  task automatic chk_pin(int kind, int expv, string tag);
    push(kind, expv, 0, tag);
    step();
  endtask

  task automatic pulse(bit u, bit a);
    upd_evt = u; alm_evt = a;
    step();
    upd_evt = 0; alm_evt = 0;
  endtask

  task automatic period(logic [7:0] aval, int expv, string tag);
    int n;
    logic prev;
    wr(4'd10, 8'h60);
    wr(4'd10, aval);
    prev = sqw;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (sqw == prev && n < 20000);
    #1;
    push(3, expv, n, tag);
    step();
  endtask

  task automatic quiet(logic [7:0] aval, string tag);
    int n;
    logic prev;
    wr(4'd10, aval);
    prev = sqw;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sqw != prev) n++;
    end
    #1;
    push(3, 0, n, tag);
    step();
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    rd(4'd10, 0, "R1 reg A reset");
    rd(4'd11, 0, "R1 reg B reset");
    rd(4'd12, 0, "R1 status reset");
    chk_pin(1, 0, "R1 irq reset");
    chk_pin(2, 0, "R1 sqw reset");

    wr(4'd10, 8'hE5); rd(4'd10, 8'h65, "R2 reg A bit7 zero");
    wr(4'd11, 8'h01); rd(4'd11, 8'h01, "R2 daylight bit");
    wr(4'd11, 8'h86); rd(4'd11, 8'h86, "R2 reg B readback");

    tick = 1;
    wr(4'd11, 8'h08);
    period(8'h03, 4, "R3 code 3");
    period(8'h06, 32, "R3 code 6");
    period(8'h0F, 16384, "R3 code 15");
    period(8'h21, 128, "R4 32k code 1");
    period(8'h22, 256, "R4 32k code 2");
    period(8'h01, 1, "R4 4M code 1");
    period(8'h12, 2, "R4 1M code 2");
    quiet(8'h00, "R3 code 0 silent");
    quiet(8'h73, "R5 hold 111 silent");
    quiet(8'h63, "R5 hold 110 silent");
    period(8'h24, 8, "R5 restart full period");

    wr(4'd10, 8'h23);
    wr(4'd11, 8'h00);
    repeat (5) step();
    chk_pin(2, 0, "R11 sqw held low");

    wr(4'd10, 8'h60);
    rd(4'd12, -1 & 8'h40, "R6 periodic flag unenabled");
    rd(4'd12, 0, "R8 cleared after read");
    pulse(1, 0);
    chk_pin(1, 0, "R7 irq low when disabled");
    rd(4'd12, 8'h10, "R6 update flag unenabled");
    wr(4'd11, 8'h10);
    pulse(1, 0);
    chk_pin(1, 1, "R7 irq high when enabled");
    rd(4'd12, 8'h90, "R7 summary bit");
    chk_pin(1, 0, "R8 irq cleared by read");
    wr(4'd11, 8'h20);
    pulse(0, 1);
    wr(4'd12, 8'hFF);
    rd(4'd12, 8'hA0, "R9 write to status ignored");
    addr = 4'd12; rd_en = 1; upd_evt = 1;
    push(0, 0, 0, "R8 read with event returns old");
    step();
    rd_en = 0; upd_evt = 0;
    rd(4'd12, 8'h10, "R8 same-cycle event kept");
    wr(4'd11, 8'h40);
    wr(4'd10, 8'h23);
    repeat (6) step();
    wr(4'd10, 8'h60);
    chk_pin(1, 1, "R7 periodic irq");
    rd(4'd12, 8'hC0, "R6 periodic flag");

    batt_ok = 1;
    wr(4'd13, 8'h00);
    rd(4'd13, 8'h80, "R10 valid bit high");
    batt_ok = 0;
    rd(4'd13, 8'h00, "R9 R10 valid bit low");

    step(); step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule